// File: doc/BRIEF.md
# Receive Request Arbiter with Header Capture

This block sits between several per-port receive streams and a frame lookup engine. Each port delivers one byte per cycle with start-of-frame, end-of-frame and a frame status flag that is valid on the end-of-frame beat. A per-port capture unit keeps the leading bytes of the frame that is arriving, up to `HDR_BYTES`. A good frame becomes a pending lookup request when it ends. A bad frame is dropped without a request.

A round-robin arbiter picks one pending port at a time. It copies that port's captured bytes into a single output header register and zero-fills every byte past the frame's length. The header, its valid-byte count and the source port number are then offered on a valid/ready handshake until the lookup engine accepts them. A port whose request is still pending ignores any new frame that starts on it.

Capture unit states: `CAP_IDLE` (waiting for a start-of-frame), `CAP_RECV` (collecting bytes) and `CAP_HOLD` (request pending). Its transitions are:
- IDLE→RECV on a start beat that is not also an end beat.
- IDLE/RECV→HOLD on a good end beat.
- IDLE/RECV→IDLE on a bad end beat.
- RECV→RECV on a fresh start beat, which restarts the capture.
- HOLD→IDLE on a grant.

Output stage states: `OUT_EMPTY` (arbiter enabled) and `OUT_FULL` (header offered). Its transitions are:
- EMPTY→FULL on a grant.
- FULL→EMPTY on a ready handshake.

Top module: `rx_header_arbiter`

## Requirements
- R1: For `b` below both the frame length and `HDR_BYTES`, header byte `b` (bits `8*b+7:8*b` of `hdr_data`) equals the `b`-th byte of the frame, and `hdr_port` gives the port the frame arrived on.
- R2: A frame whose status flag is low on its end-of-frame beat produces no header output.
- R3: A port's request rises only in the cycle after a good end-of-frame beat on that port. It stays pending until that port is granted.
- R4: Grants go round-robin. The search starts at the port after the one granted last, and after reset port 0 is searched first. At most one port is granted at a time, and only a requesting port.
- R5: A frame longer than `HDR_BYTES` gives `hdr_len` = `HDR_BYTES` and only its leading `HDR_BYTES` bytes.
- R6: A frame shorter than `HDR_BYTES` gives `hdr_len` equal to its length, and every header byte at or above that length is zero. A one-byte frame (start and end on the same beat) is valid.
- R7: Once `hdr_valid` is high, it stays high and `hdr_data`, `hdr_len` and `hdr_port` stay stable until a cycle with `hdr_ready` high.
- R8: A frame that starts on a port whose request is still pending is ignored, and the bytes captured earlier on that port are kept.
- R9: During and right after reset, `hdr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | NUM_PORTS | Byte valid, one bit per port |
| rx_data | input | NUM_PORTS*8 | Byte lanes, port p in bits 8p+7:8p |
| rx_sof | input | NUM_PORTS | First byte of a frame |
| rx_eof | input | NUM_PORTS | Last byte of a frame |
| rx_good | input | NUM_PORTS | Frame status, sampled with rx_eof (1 = good) |
| hdr_valid | output | 1 | Captured header offered |
| hdr_ready | input | 1 | Lookup engine accepts the header |
| hdr_data | output | HDR_BYTES*8 | Header bytes, byte 0 in the low bits |
| hdr_len | output | $clog2(HDR_BYTES+1) | Number of valid header bytes |
| hdr_port | output | $clog2(NUM_PORTS) | Source port of the header |

## Verification
The bench builds the block with four ports and a 64-byte header. With four ports, the round-robin pointer wraps from the last port back to port 0 within one burst of simultaneous requests. With a 64-byte header, a 100-byte frame reaches the truncation case and a 64-byte frame hits the exact boundary. Holding ready low while all four ports have requests pending leaves one header parked at the output. That makes it possible to check that the output stays stable and that a port with a pending request ignores a new frame.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_RECV = 2'd1,
        CAP_HOLD = 2'd2
    } cap_state_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/rxa_port_capture.sv
module rxa_port_capture
    import rxa_pkg::*;
#(
    parameter int HDR_BYTES = 64,
    parameter int LEN_W     = $clog2(HDR_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic                   in_good,
    input  logic                   grant,
    output logic                   req,
    output logic [HDR_BYTES*8-1:0] cap_bytes,
    output logic [LEN_W-1:0]       cap_len
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(HDR_BYTES);

    cap_state_e state_q, state_d;
    logic       load_first, load_next;
    logic [HDR_BYTES*8-1:0] buf_q;
    logic [LEN_W-1:0]       len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        load_first = 1'b0;
        load_next  = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (in_valid && in_sof) begin
                    load_first = 1'b1;
                    if (in_eof) state_d = in_good ? CAP_HOLD : CAP_IDLE;
                    else        state_d = CAP_RECV;
                end
            end
            CAP_RECV: begin
                if (in_valid) begin
                    if (in_sof) load_first = 1'b1;
                    else        load_next  = 1'b1;
                    if (in_eof) state_d = in_good ? CAP_HOLD : CAP_IDLE;
                end
            end
            CAP_HOLD: begin
                if (grant) state_d = CAP_IDLE;
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            len_q <= '0;
        end else if (load_first) begin
            buf_q[7:0] <= in_data;
            len_q      <= LEN_W'(1);
        end else if (load_next && (len_q < LEN_MAX)) begin
            buf_q[len_q*8 +: 8] <= in_data;
            len_q               <= len_q + LEN_W'(1);
        end
    end

    always_comb begin
        req       = (state_q == CAP_HOLD);
        cap_bytes = buf_q;
        cap_len   = len_q;
    end

endmodule

// File: rtl/rxa_rr_arbiter.sv
module rxa_rr_arbiter #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [NUM_PORTS-1:0] req,
    output logic [NUM_PORTS-1:0] grant,
    output logic [PORT_W-1:0]    grant_idx,
    output logic                 grant_any
);

    logic [PORT_W-1:0] last_q;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int k = 1; k <= NUM_PORTS; k++) begin
            if (!grant_any && enable && req[(int'(last_q) + k) % NUM_PORTS]) begin
                grant_any = 1'b1;
                grant[(int'(last_q) + k) % NUM_PORTS] = 1'b1;
                grant_idx = PORT_W'((int'(last_q) + k) % NUM_PORTS);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= PORT_W'(NUM_PORTS - 1);
        else if (grant_any) last_q <= grant_idx;
    end

endmodule

// File: rtl/rxa_hdr_out.sv
module rxa_hdr_out
    import rxa_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int HDR_BYTES = 64,
    parameter int LEN_W     = $clog2(HDR_BYTES + 1),
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  grant_any,
    input  logic [PORT_W-1:0]                     grant_idx,
    input  logic [NUM_PORTS-1:0][HDR_BYTES*8-1:0] stage_bytes,
    input  logic [NUM_PORTS-1:0][LEN_W-1:0]       stage_len,
    input  logic                                  hdr_ready,
    output logic                                  arb_enable,
    output logic                                  hdr_valid,
    output logic [HDR_BYTES*8-1:0]                hdr_data,
    output logic [LEN_W-1:0]                      hdr_len,
    output logic [PORT_W-1:0]                     hdr_port
);

    out_state_e state_q, state_d;
    logic [HDR_BYTES*8-1:0] sel_bytes, masked;
    logic [LEN_W-1:0]       sel_len;
    logic [HDR_BYTES*8-1:0] data_q;
    logic [LEN_W-1:0]       len_q;
    logic [PORT_W-1:0]      port_q;
    logic                   load;

    assign sel_bytes = stage_bytes[grant_idx];
    assign sel_len   = stage_len[grant_idx];

    for (genvar b = 0; b < HDR_BYTES; b++) begin : g_pad
        assign masked[b*8 +: 8] = (sel_len > LEN_W'(b)) ? sel_bytes[b*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            OUT_EMPTY: if (grant_any) begin
                state_d = OUT_FULL;
                load    = 1'b1;
            end
            OUT_FULL:  if (hdr_ready) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            len_q  <= '0;
            port_q <= '0;
        end else if (load) begin
            data_q <= masked;
            len_q  <= sel_len;
            port_q <= grant_idx;
        end
    end

    always_comb begin
        arb_enable = (state_q == OUT_EMPTY);
        hdr_valid  = (state_q == OUT_FULL);
        hdr_data   = data_q;
        hdr_len    = len_q;
        hdr_port   = port_q;
    end

endmodule

// File: rtl/rx_header_arbiter.sv
module rx_header_arbiter #(
    parameter int NUM_PORTS = 4,
    parameter int HDR_BYTES = 64,
    localparam int LEN_W    = $clog2(HDR_BYTES + 1),
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PORTS-1:0]   rx_valid,
    input  logic [NUM_PORTS*8-1:0] rx_data,
    input  logic [NUM_PORTS-1:0]   rx_sof,
    input  logic [NUM_PORTS-1:0]   rx_eof,
    input  logic [NUM_PORTS-1:0]   rx_good,
    output logic                   hdr_valid,
    input  logic                   hdr_ready,
    output logic [HDR_BYTES*8-1:0] hdr_data,
    output logic [LEN_W-1:0]       hdr_len,
    output logic [PORT_W-1:0]      hdr_port
);

    logic [NUM_PORTS-1:0]                  port_req;
    logic [NUM_PORTS-1:0]                  arb_grant;
    logic [NUM_PORTS-1:0][HDR_BYTES*8-1:0] stage_bytes;
    logic [NUM_PORTS-1:0][LEN_W-1:0]       stage_len;
    logic [PORT_W-1:0]                     grant_idx;
    logic                                  grant_any;
    logic                                  arb_enable;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rxa_port_capture #(
            .HDR_BYTES (HDR_BYTES),
            .LEN_W     (LEN_W)
        ) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (rx_valid[p]),
            .in_data   (rx_data[p*8 +: 8]),
            .in_sof    (rx_sof[p]),
            .in_eof    (rx_eof[p]),
            .in_good   (rx_good[p]),
            .grant     (arb_grant[p]),
            .req       (port_req[p]),
            .cap_bytes (stage_bytes[p]),
            .cap_len   (stage_len[p])
        );
    end

    rxa_rr_arbiter #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (arb_enable),
        .req       (port_req),
        .grant     (arb_grant),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    rxa_hdr_out #(
        .NUM_PORTS (NUM_PORTS),
        .HDR_BYTES (HDR_BYTES),
        .LEN_W     (LEN_W),
        .PORT_W    (PORT_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_any   (grant_any),
        .grant_idx   (grant_idx),
        .stage_bytes (stage_bytes),
        .stage_len   (stage_len),
        .hdr_ready   (hdr_ready),
        .arb_enable  (arb_enable),
        .hdr_valid   (hdr_valid),
        .hdr_data    (hdr_data),
        .hdr_len     (hdr_len),
        .hdr_port    (hdr_port)
    );

endmodule

// File: rtl/rxa_checker.sv
module rxa_checker #(
    parameter int NUM_PORTS = 4,
    parameter int HDR_BYTES = 64,
    parameter int LEN_W     = $clog2(HDR_BYTES + 1),
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PORTS-1:0]   rx_valid,
    input logic [NUM_PORTS-1:0]   rx_eof,
    input logic [NUM_PORTS-1:0]   rx_good,
    input logic [NUM_PORTS-1:0]   port_req,
    input logic [NUM_PORTS-1:0]   arb_grant,
    input logic                   hdr_valid,
    input logic                   hdr_ready,
    input logic [HDR_BYTES*8-1:0] hdr_data,
    input logic [LEN_W-1:0]       hdr_len,
    input logic [PORT_W-1:0]      hdr_port
);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_data)
                                       && $stable(hdr_len) && $stable(hdr_port)));

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant));

    // R4
    grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_grant & ~port_req) == '0);

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_len != '0 && hdr_len <= LEN_W'(HDR_BYTES)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
        // R3
        req_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_req[p]) |-> $past(rx_valid[p] && rx_eof[p] && rx_good[p]));
    end

    // R6
    always @(posedge clk) begin
        if (rst_n && hdr_valid) begin
            for (int b = 0; b < HDR_BYTES; b++) begin
                if (LEN_W'(b) >= hdr_len)
                    pad_zero_chk: assert (hdr_data[b*8 +: 8] == 8'h00);
            end
        end
    end

endmodule

bind rx_header_arbiter rxa_checker #(
    .NUM_PORTS (NUM_PORTS),
    .HDR_BYTES (HDR_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_eof    (rx_eof),
    .rx_good   (rx_good),
    .port_req  (port_req),
    .arb_grant (arb_grant),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .hdr_data  (hdr_data),
    .hdr_len   (hdr_len),
    .hdr_port  (hdr_port)
);

// File: tb/sim_rx_header_arbiter.sv
module sim_rx_header_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int HB   = 64;
    localparam int LW   = $clog2(HB + 1);
    localparam int PW   = $clog2(NP);

    typedef struct {
        int              port;
        int              len;
        logic [HB*8-1:0] data;
        string           tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     rx_valid = '0;
    logic [NP*8-1:0]   rx_data = '0;
    logic [NP-1:0]     rx_sof = '0;
    logic [NP-1:0]     rx_eof = '0;
    logic [NP-1:0]     rx_good = '0;
    logic              hdr_ready = 1'b1;
    logic              hdr_valid;
    logic [HB*8-1:0]   hdr_data;
    logic [LW-1:0]     hdr_len;
    logic [PW-1:0]     hdr_port;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_header_arbiter #(.NUM_PORTS(NP), .HDR_BYTES(HB)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
        .hdr_len(hdr_len), .hdr_port(hdr_port)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input int p, input int len, input logic [7:0] seed, input string tag);
        exp_t e;
        e.port = p;
        e.len  = (len > HB) ? HB : len;
        e.data = '0;
        for (int b = 0; b < HB; b++)
            if (b < len) e.data[b*8 +: 8] = seed + 8'(b);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send_frame(input int p, input int len, input bit good, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid[p]         = 1'b1;
            rx_data[p*8 +: 8]   = seed + 8'(i);
            rx_sof[p]           = (i == 0);
            rx_eof[p]           = (i == len - 1);
            rx_good[p]          = good;
        end
        @(negedge clk);
        rx_valid[p] = 1'b0;
        rx_sof[p]   = 1'b0;
        rx_eof[p]   = 1'b0;
        rx_good[p]  = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (sb.size() != 0 || hdr_valid); i++)
            @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected headers on each handshake
    always begin
        @(negedge clk);
        #1;
        if (rst_n && hdr_valid && hdr_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected header from port", longint'(hdr_port), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(hdr_port) == e.port, e.tag, "port", longint'(hdr_port), e.port);
                check(int'(hdr_len) == e.len, e.tag, "length", longint'(hdr_len), e.len);
                n_checks++;
                if (hdr_data !== e.data) begin
                    n_fail++;
                    $display("FAIL %s data: actual %h expected %h", e.tag, hdr_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9
        check(hdr_valid == 1'b0, "R9", "valid in reset", hdr_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hdr_valid == 1'b0, "R9", "valid after reset", hdr_valid, 0);

        // R1 R6: short frame on port 2
        push_exp(2, 10, 8'h20, "R1/R6 short");
        send_frame(2, 10, 1'b1, 8'h20);
        drain();

        // R2: bad frame on port 1 gives nothing
        send_frame(1, 12, 1'b0, 8'h55);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            check(hdr_valid == 1'b0, "R2", "valid after bad frame", hdr_valid, 0);
        end

        // R5: long frame truncated
        push_exp(3, 100, 8'h80, "R5 long");
        send_frame(3, 100, 1'b1, 8'h80);
        drain();

        // R5 R1: exact length frame on port 0
        push_exp(0, 64, 8'hC0, "R5 exact");
        send_frame(0, 64, 1'b1, 8'hC0);
        drain();

        // R4: all ports end together, last grant was port 0 -> order 1,2,3,0
        hdr_ready = 1'b0;
        push_exp(1, 8, 8'h10, "R4 rr1");
        push_exp(2, 8, 8'h30, "R4 rr2");
        push_exp(3, 8, 8'h50, "R4 rr3");
        push_exp(0, 8, 8'h70, "R4 rr0");
        fork
            send_frame(0, 8, 1'b1, 8'h70);
            send_frame(1, 8, 1'b1, 8'h10);
            send_frame(2, 8, 1'b1, 8'h30);
            send_frame(3, 8, 1'b1, 8'h50);
        join
        repeat (3) @(negedge clk);
        #1;
        check(hdr_valid == 1'b1, "R7", "valid held", hdr_valid, 1);
        check(int'(hdr_port) == 1, "R4", "first grant", longint'(hdr_port), 1);
        // R8: port 2 is pending; this frame must be ignored
        send_frame(2, 5, 1'b1, 8'hEE);
        repeat (4) @(negedge clk);
        #1;
        check(hdr_valid == 1'b1 && int'(hdr_port) == 1, "R7", "held port", longint'(hdr_port), 1);
        @(negedge clk);
        hdr_ready = 1'b1;
        drain();

        // R6: single-byte frame
        push_exp(1, 1, 8'hA5, "R6 single");
        send_frame(1, 1, 1'b1, 8'hA5);
        drain();

        // R8 R2: nothing left over
        check(sb.size() == 0, "R8", "pending expected items", sb.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule